// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the slave end of a two-wire serial bus (clock line plus open-drain data line) that lets an external master read and write a small bank of status and control registers. Both bus lines are brought into the system clock domain through synchronizers. Start and stop conditions and clock edges are derived from the synchronized copies. A transaction is decoded byte by byte: a device byte, a register address byte, then one or more data bytes. The block never drives the data line high. It only asserts a pull-low request, which the pad turns into an open-drain driver.

The register bank lives outside the block. Committed writes leave through a one-cycle write strobe with an address and data. Reads present a register pointer and take the byte back combinationally on `rd_data_i`. The write strobe has no ready input, because a two-wire bus without clock stretching cannot be held off. The consumer must accept every strobe in the cycle it is raised. `rd_data_i` must be valid for the current `rd_addr_o` in every cycle, because it is captured on the SCL falling edge that begins each transmitted byte.

The device byte layout is as follows. Bits 7:4 hold the device identifier, 4'b0101. Bits 3:1 hold the select value, 3'b000. Bit 0 gives the direction, with 0 for write and 1 for read. Register address 0 is the status register. Addresses from 0 up to NUM_REGS-1 (default 4) are defined.

Top module: `twi_reg_slave`

## Requirements
- R1: An SDA transition is treated as a start or stop only when SCL is high in both the previous and current synchronized samples. An SDA change that reaches the block in the same system clock cycle as an SCL rise is taken as the data bit, not as a condition.
- R2: Until a start condition has been seen, the block ignores all bus activity. It never pulls SDA and produces no write strobe.
- R3: The slave pulls SDA low during the ninth clock of the device byte only when bits 7:4 equal 4'b0101 and bits 3:1 equal 3'b000. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R4: A stop condition (SDA rising while SCL is high) ends any transaction, releases SDA and returns the block to idle. Later bytes without a new start are not acknowledged.
- R5: In a write, the register address byte and each data byte are acknowledged. Each data byte is committed as a single-cycle `wr_en_o` pulse on the ninth SCL rise, with `wr_addr_o` set to the register address. Further data bytes to a control register rewrite the same address.
- R6: Data written to an address of NUM_REGS or above is acknowledged, but no write strobe is produced.
- R7: For the status register (address 0), the first data byte is acknowledged and written. A second data byte in the same transaction is not acknowledged and not written.
- R8: `sda_pull_o` = 1 means SDA is pulled low; the block has no way to drive SDA high. The pull request changes only after a synchronized SCL falling edge, so it is stable while SCL is high.
- R9: After a device byte with bit 0 = 1, the slave transmits the byte at `rd_data_i` for pointer `rd_addr_o` MSB first. If the master acknowledges, the slave sends the same register again. If the master does not acknowledge, the slave releases SDA and waits for a stop or a start.
- R10: A repeated start in the middle of a transaction restarts decoding at the device byte. The register pointer set by an earlier address byte is kept for a following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Data of the write |
| rd_addr_o | output | 8 | Register pointer for reads |
| rd_data_i | input | 8 | Register contents at `rd_addr_o` |

## Verification
Start/stop detection and bit sampling both read the same synchronized SDA sample. They collide when SDA and SCL change in the same system clock cycle. To provoke this, the bench runs a whole write transaction in which every data bit is placed on SDA at the same instant SCL rises. This includes 0-to-1 and 1-to-0 moves that would look like stop or start if SCL were seen as already high. The collision is judged correct when every byte is acknowledged and the write strobe carries exactly the bytes sent, with no spurious restart or abort.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD,
    ST_WAIT
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  logic [LINES-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '1;
      else if (s == 0) stage[s] <= d_i;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // conditions need SCL high on both samples
  assign start_o = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q &  sda_s;
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/twi_xfer_ctl.sv
module twi_xfer_ctl
  import twi_pkg::*;
#(
  parameter logic [3:0]  DEV_ID      = 4'b0101,
  parameter logic [2:0]  DEV_SEL     = 3'b000,
  parameter int unsigned NUM_REGS    = 4,
  parameter logic [7:0]  STATUS_ADDR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              pull_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o
);
  localparam logic [BYTE_W:0]  REG_LIMIT = (BYTE_W+1)'(NUM_REGS);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CLK   = CNT_W'(BYTE_W + 1);

  twi_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              second;
  logic              mack;
  logic              ack_ok;
  logic              in_map;

  assign in_map = {1'b0, ptr_o} < REG_LIMIT;

  always_comb begin
    unique case (st)
      ST_DEV:  ack_ok = (sh[7:4] == DEV_ID) && (sh[3:1] == DEV_SEL);
      ST_REG:  ack_ok = 1'b1;
      ST_WR:   ack_ok = !(second && (ptr_o == STATUS_ADDR));
      default: ack_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      second    <= 1'b0;
      mack      <= 1'b0;
      pull_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      ptr_o     <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st     <= ST_DEV;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else if (stop_i) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_REG, ST_WR: begin
            if (rise_i) begin
              if (cnt < LAST_BIT) begin
                sh  <= {sh[BYTE_W-2:0], sda_i};
                cnt <= cnt + 1'b1;
              end else if (cnt == LAST_BIT) begin
                cnt <= ACK_CLK;
                if (st == ST_WR && in_map) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_o;
                  wr_data_o <= sh;
                end
              end
            end else if (fall_i) begin
              if (cnt == LAST_BIT) begin
                if (ack_ok) pull_o <= 1'b1;
                else        st     <= ST_WAIT;
              end else if (cnt == ACK_CLK) begin
                pull_o <= 1'b0;
                cnt    <= '0;
                unique case (st)
                  ST_DEV: begin
                    if (sh[0]) begin
                      st     <= ST_RD;
                      sh     <= rd_data_i;
                      pull_o <= ~rd_data_i[BYTE_W-1];
                    end else begin
                      st <= ST_REG;
                    end
                  end
                  ST_REG: begin
                    ptr_o  <= sh;
                    second <= 1'b0;
                    st     <= ST_WR;
                  end
                  default: second <= 1'b1;
                endcase
              end
            end
          end
          ST_RD: begin
            if (rise_i) begin
              if (cnt < LAST_BIT) cnt <= cnt + 1'b1;
              else if (cnt == LAST_BIT) begin
                mack <= ~sda_i;
                cnt  <= ACK_CLK;
              end
            end else if (fall_i) begin
              if (cnt != '0 && cnt < LAST_BIT) begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                pull_o <= ~sh[BYTE_W-2];
              end else if (cnt == LAST_BIT) begin
                pull_o <= 1'b0;
              end else if (cnt == ACK_CLK) begin
                cnt <= '0;
                if (mack) begin
                  sh     <= rd_data_i;
                  pull_o <= ~rd_data_i[BYTE_W-1];
                end else begin
                  st <= ST_WAIT;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter logic [3:0]  DEV_ID      = 4'b0101,
  parameter logic [2:0]  DEV_SEL     = 3'b000,
  parameter int unsigned NUM_REGS    = 4,
  parameter logic [7:0]  STATUS_ADDR = 8'h00,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  logic [1:0] lines_s;
  logic       start_ev, stop_ev, scl_rise, scl_fall;

  twi_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  twi_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (lines_s[1]),
    .sda_s   (lines_s[0]),
    .start_o (start_ev),
    .stop_o  (stop_ev),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall)
  );

  twi_xfer_ctl #(
    .DEV_ID      (DEV_ID),
    .DEV_SEL     (DEV_SEL),
    .NUM_REGS    (NUM_REGS),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_ev),
    .stop_i    (stop_ev),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .sda_i     (lines_s[0]),
    .rd_data_i (rd_data_i),
    .pull_o    (sda_pull_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .ptr_o     (rd_addr_o)
  );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk #(
  parameter int unsigned NUM_REGS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic       wr_en_o,
  input logic [7:0] wr_addr_o,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev
);
  localparam logic [8:0] LIMIT = 9'(NUM_REGS);

  p_wr_in_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ({1'b0, wr_addr_o} < LIMIT));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  p_pull_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));

  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull_o);

  p_start_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!sda_pull_o && !wr_en_o));
endmodule

bind twi_reg_slave twi_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_pull_o (sda_pull_o),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .scl_fall   (scl_fall),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev)
);

// File: tb/twi_reg_slave_bench.sv
`timescale 1ns/1ps
module twi_reg_slave_bench;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_pull_o, wr_en_o;
  logic [7:0] wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;
  logic [7:0] regs [4];

  int checks = 0, fails = 0, wr_cnt = 0, od_viol = 0;
  logic [7:0] last_a, last_d;
  logic pull_q = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_pull_o;
  assign rd_data_i = (rd_addr_o < 8'd4) ? regs[rd_addr_o[1:0]] : 8'hEE;

  twi_reg_slave u_twi_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en_o) begin
        wr_cnt++;
        last_a = wr_addr_o;
        last_d = wr_data_o;
        if (wr_addr_o < 8'd4) regs[wr_addr_o[1:0]] = wr_data_o;
      end
      if (sda_pull_o != pull_q && scl_m) od_viol++;
      pull_q = sda_pull_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send(input logic [7:0] b, input bit late, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      if (late) begin
        wt(Q); sda_m = b[i]; scl_m = 1'b1;
      end else begin
        sda_m = b[i]; wt(Q); scl_m = 1'b1;
      end
      wt(Q); scl_m = 1'b0;
    end
    wt(1); sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q/2); ack = (sda_bus == 1'b0); wt(Q/2);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q/2); b[i] = sda_bus; wt(Q/2); scl_m = 1'b0;
    end
    wt(1); sda_m = ~mack; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0;
    wt(1); sda_m = 1'b1; wt(Q);
  endtask

  task automatic t_reset;
    chk(sda_pull_o == 1'b0, "R8", "pull at reset", sda_pull_o, 0);
    chk(wr_en_o == 1'b0, "R2", "wr_en at reset", wr_en_o, 0);
  endtask

  task automatic t_no_start;
    bit a; int w0 = wr_cnt;
    send(8'h50, 0, a);
    chk(a == 0, "R2", "ack before start", a, 0);
    chk(wr_cnt == w0, "R2", "writes before start", wr_cnt, w0);
  endtask

  task automatic t_write_ctrl;
    bit a; int w0 = wr_cnt;
    bus_start;
    send(8'h50, 0, a); chk(a, "R3", "device ack", a, 1);
    send(8'h01, 0, a); chk(a, "R5", "reg addr ack", a, 1);
    send(8'hA5, 0, a); chk(a, "R5", "data ack", a, 1);
    chk(wr_cnt == w0 + 1, "R5", "write count", wr_cnt, w0 + 1);
    chk(last_a == 8'h01 && last_d == 8'hA5, "R5", "write addr/data",
        {last_a, last_d}, 16'h01A5);
    bus_stop;
    chk(sda_pull_o == 0, "R4", "pull after stop", sda_pull_o, 0);
  endtask

  task automatic t_bad_dev;
    bit a; int w0 = wr_cnt;
    bus_start;
    send(8'h70, 0, a); chk(a == 0, "R3", "wrong id nack", a, 0);
    send(8'h01, 0, a); chk(a == 0, "R3", "ignored after mismatch", a, 0);
    bus_stop;
    bus_start;
    send(8'h52, 0, a); chk(a == 0, "R3", "wrong select nack", a, 0);
    bus_stop;
    chk(wr_cnt == w0, "R3", "no writes", wr_cnt, w0);
  endtask

  task automatic t_undef;
    bit a; int w0 = wr_cnt;
    bus_start;
    send(8'h50, 0, a);
    send(8'h09, 0, a); chk(a, "R6", "undef addr ack", a, 1);
    send(8'h42, 0, a); chk(a, "R6", "undef data ack", a, 1);
    bus_stop;
    chk(wr_cnt == w0, "R6", "undef write dropped", wr_cnt, w0);
  endtask

  task automatic t_status;
    bit a; int w0 = wr_cnt; logic [7:0] d;
    bus_start;
    send(8'h50, 0, a); send(8'h00, 0, a);
    send(8'h11, 0, a); chk(a, "R7", "status first byte ack", a, 1);
    send(8'h22, 0, a); chk(a == 0, "R7", "status second byte nack", a, 0);
    bus_stop;
    chk(wr_cnt == w0 + 1, "R7", "status single write", wr_cnt, w0 + 1);
    bus_start;
    send(8'h50, 0, a); send(8'h00, 0, a);
    bus_start;
    send(8'h51, 0, a); recv(0, d);
    bus_stop;
    chk(d == 8'h11, "R7", "status readback", d, 8'h11);
  endtask

  task automatic t_ctrl_multi;
    bit a; int w0 = wr_cnt;
    bus_start;
    send(8'h50, 0, a); send(8'h02, 0, a);
    send(8'h33, 0, a); chk(a, "R5", "ctrl byte1 ack", a, 1);
    send(8'h44, 0, a); chk(a, "R5", "ctrl byte2 ack", a, 1);
    bus_stop;
    chk(wr_cnt == w0 + 2, "R5", "ctrl two writes", wr_cnt, w0 + 2);
    chk(last_a == 8'h02 && last_d == 8'h44, "R5", "ctrl same addr",
        {last_a, last_d}, 16'h0244);
  endtask

  task automatic t_read;
    bit a; logic [7:0] d;
    bus_start;
    send(8'h50, 0, a); send(8'h01, 0, a);
    bus_start;
    send(8'h51, 0, a); chk(a, "R9", "read device ack", a, 1);
    chk(rd_addr_o == 8'h01, "R9", "read pointer", rd_addr_o, 1);
    recv(1, d); chk(d == 8'hA5, "R9", "read byte 1", d, 8'hA5);
    recv(0, d); chk(d == 8'hA5, "R9", "read byte 2", d, 8'hA5);
    chk(sda_pull_o == 0, "R9", "release after master nack", sda_pull_o, 0);
    bus_stop;
  endtask

  task automatic t_restart;
    bit a; int w0 = wr_cnt;
    bus_start;
    send(8'h50, 0, a); send(8'h02, 0, a);
    bus_start;
    send(8'h50, 0, a); chk(a, "R10", "device ack after restart", a, 1);
    send(8'h03, 0, a); send(8'h77, 0, a);
    bus_stop;
    chk(wr_cnt == w0 + 1, "R10", "one write", wr_cnt, w0 + 1);
    chk(last_a == 8'h03 && last_d == 8'h77, "R10", "write after restart",
        {last_a, last_d}, 16'h0377);
  endtask

  task automatic t_coincident;
    bit a; int w0 = wr_cnt;
    bus_start;
    send(8'h50, 1, a); chk(a, "R1", "device ack, coincident edges", a, 1);
    send(8'h02, 1, a); chk(a, "R1", "reg ack, coincident edges", a, 1);
    send(8'h5A, 1, a); chk(a, "R1", "data ack, coincident edges", a, 1);
    bus_stop;
    chk(wr_cnt == w0 + 1 && last_a == 8'h02 && last_d == 8'h5A, "R1",
        "coincident write", {last_a, last_d}, 16'h025A);
  endtask

  task automatic t_stop_mid;
    bit a;
    bus_start;
    send(8'h50, 0, a);
    bus_stop;
    chk(sda_pull_o == 0, "R4", "pull after mid stop", sda_pull_o, 0);
    send(8'h50, 0, a); chk(a == 0, "R4", "idle after stop", a, 0);
  endtask

  initial begin
    regs[0] = 8'h3C; regs[1] = 8'h00; regs[2] = 8'h00; regs[3] = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);
    t_reset;
    scl_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
    t_no_start;
    t_write_ctrl;
    t_bad_dev;
    t_undef;
    t_status;
    t_ctrl_multi;
    t_read;
    t_restart;
    t_coincident;
    t_stop_mid;
    chk(od_viol == 0, "R8", "pull changed with SCL high", od_viol, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule